// File: doc/BRIEF.md
# Dual-Bank Column Hole Parity Checker

This block catches errors in card reads by keeping a short summary of each column rather than a full hole count. A card passes two read stations in turn. At the first station its rows are summarised (the count pass). At the second station the same rows are read again and cancel that summary (the verify pass). Each column keeps two bits. The presence bit U is set by a hole during the count pass and cleared by a hole during the verify pass. The parity bit L flips on every hole in either pass. If the two reads agree, every bit of the card is zero once the verify pass ends.

Two banks of these bits are held in parallel. At any time one bank counts the card at the first station while the other verifies the previous card at the second station. The two roles swap on every end-of-card strobe. At that strobe the verifying bank is examined and then cleared, so it is ready to count the next card. The block reports a one-cycle result pulse, an error flag and the lowest failing column number.

Top module: `card_hole_checker`

## Requirements
- R1: After synchronous reset, err_valid, err_flag and err_col are 0 and both banks are empty, so the first card_end reports no error.
- R2: A row is applied to a bank only in a cycle where its strobe (cnt_valid or ver_valid) is high. Row data presented with the strobe low has no effect. Bit k of a row vector is column k+1.
- R3: In the count pass a hole sets U and flips L. In the verify pass a hole clears U and flips L. A verify pass that repeats the count pass exactly reports no error.
- R4: At card_end, err_flag is set if any U or L bit of the verifying bank is 1 in any column. A column holed at the first station and holed nowhere at the second station is flagged.
- R5: A column with no holes at the first station is flagged only if it has an odd number of holes at the second station. With two extra holes it is not flagged.
- R6: Miscounts of the same parity in a column that has at least one hole at each station (for example 1 versus 3) are not flagged.
- R7: After reset bank 0 counts. Each card_end swaps the counting and verifying banks, so card n is counted while card n-1 is verified in the same row times, and neither disturbs the other.
- R8: The verifying bank is cleared at card_end. A card counted into it afterwards is judged only on its own holes.
- R9: err_col is the lowest failing column number, from 1 to NCOLS, and is 0 when there is no error.
- R10: err_valid is high for exactly the one cycle after card_end. err_flag and err_col change only on that cycle and hold until the next card_end.
- R11: Rows strobed in the same cycle as card_end are applied before the result is formed. The counted row enters the bank that counts the next verify pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_valid | input | 1 | First-station row strobe |
| cnt_row | input | NCOLS | First-station hole vector, bit k = column k+1 |
| ver_valid | input | 1 | Second-station row strobe |
| ver_row | input | NCOLS | Second-station hole vector, bit k = column k+1 |
| card_end | input | 1 | End of card: judge the verifying bank and swap the banks |
| err_valid | output | 1 | One-cycle pulse, the cycle after card_end |
| err_flag | output | 1 | The last verified card failed |
| err_col | output | $clog2(NCOLS+1) | Lowest failing column (1..NCOLS), 0 when none |

## Verification
The hardest states to reach are those where the parity bit L hides or exposes a miscount in a particular column. These include a single extra hole at the second station in a column that was empty at the first station, two such holes, and a 1-versus-3 count. A second hard case is a bank that held error bits when it was judged and must come back clean. The bench reaches these with directed cards that place holes in chosen rows of chosen columns, among them columns 1 and 80. These cards follow each other, so every result depends on the bank swap and on the clear of the previous verify. A sweep of generated cards then replays each counted card at the second station with one column altered: a bit flipped, a column dropped, or holes added. The expected error and column come from per-column OR and parity sums computed in the bench.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic {
    ROLE_VERIFY = 1'b0,
    ROLE_COUNT  = 1'b1
  } role_e;
endpackage

// File: rtl/hpc_bank.sv
module hpc_bank
  import hpc_pkg::*;
#(
  parameter int NCOLS = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  role_e            role,
  input  logic             row_valid,
  input  logic [NCOLS-1:0] row,
  input  logic             clear,
  output logic [NCOLS-1:0] u_next,
  output logic [NCOLS-1:0] l_next
);
  logic [NCOLS-1:0] u_q, l_q;

  // Next state with the current row applied; the top judges this value
  always_comb begin
    u_next = u_q;
    l_next = l_q;
    if (row_valid) begin
      l_next = l_q ^ row;
      u_next = (role == ROLE_COUNT) ? (u_q | row) : (u_q & ~row);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      u_q <= '0;
      l_q <= '0;
    end else begin
      u_q <= u_next;
      l_q <= l_next;
    end
  end
endmodule

// File: rtl/hpc_lowest.sv
module hpc_lowest #(
  parameter int N  = 80,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i + 1);
    end
  end
endmodule

// File: rtl/card_hole_checker.sv
module card_hole_checker
  import hpc_pkg::*;
#(
  parameter int NCOLS = 80,
  localparam int IDXW = $clog2(NCOLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_valid,
  input  logic [NCOLS-1:0] cnt_row,
  input  logic             ver_valid,
  input  logic [NCOLS-1:0] ver_row,
  input  logic             card_end,
  output logic             err_valid,
  output logic             err_flag,
  output logic [IDXW-1:0]  err_col
);
  logic             sel_q;        // index of the bank now counting
  logic             ver_idx;
  logic [NCOLS-1:0] u_nx [2];
  logic [NCOLS-1:0] l_nx [2];
  logic [NCOLS-1:0] fail_vec;
  logic             fail_any;
  logic [IDXW-1:0]  fail_idx;

  assign ver_idx = ~sel_q;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    role_e role_g;
    assign role_g = (sel_q == 1'(g)) ? ROLE_COUNT : ROLE_VERIFY;
    hpc_bank #(.NCOLS(NCOLS)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .role      (role_g),
      .row_valid ((role_g == ROLE_COUNT) ? cnt_valid : ver_valid),
      .row       ((role_g == ROLE_COUNT) ? cnt_row : ver_row),
      .clear     (card_end && (role_g == ROLE_VERIFY)),
      .u_next    (u_nx[g]),
      .l_next    (l_nx[g])
    );
  end

  assign fail_vec = u_nx[ver_idx] | l_nx[ver_idx];

  hpc_lowest #(.N(NCOLS), .IW(IDXW)) u_lowest (
    .vec (fail_vec),
    .any (fail_any),
    .idx (fail_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      err_valid <= 1'b0;
      err_flag  <= 1'b0;
      err_col   <= '0;
    end else begin
      err_valid <= card_end;
      if (card_end) begin
        sel_q    <= ~sel_q;
        err_flag <= fail_any;
        err_col  <= fail_idx;
      end
    end
  end
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int NCOLS = 80,
  localparam int IDXW = $clog2(NCOLS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            card_end,
  input logic            err_valid,
  input logic            err_flag,
  input logic [IDXW-1:0] err_col,
  input logic            sel
);
  p_pulse_after_end_r10: assert property (@(posedge clk) disable iff (rst)
    card_end |=> err_valid);
  p_no_stray_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !card_end |=> !err_valid);
  p_result_held_r10: assert property (@(posedge clk) disable iff (rst)
    !card_end |=> ($stable(err_flag) && $stable(err_col)));
  p_col_range_r9: assert property (@(posedge clk) disable iff (rst)
    err_col <= IDXW'(NCOLS));
  p_flag_has_col_r4: assert property (@(posedge clk) disable iff (rst)
    err_flag == (err_col != '0));
  p_swap_r7: assert property (@(posedge clk) disable iff (rst)
    card_end |=> (sel != $past(sel)));
  p_no_swap_r7: assert property (@(posedge clk) disable iff (rst)
    !card_end |=> $stable(sel));
endmodule

bind card_hole_checker hpc_checker #(.NCOLS(NCOLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .card_end  (card_end),
  .err_valid (err_valid),
  .err_flag  (err_flag),
  .err_col   (err_col),
  .sel       (sel_q)
);

// File: tb/card_hole_checker_test.sv
module card_hole_checker_test;
  localparam int N    = 80;
  localparam int ROWS = 12;
  localparam int IW   = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_valid = 1'b0, ver_valid = 1'b0, card_end = 1'b0;
  logic [N-1:0]  cnt_row = '0, ver_row = '0;
  logic          err_valid, err_flag;
  logic [IW-1:0] err_col;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] cq [ROWS];
  logic [N-1:0] vq [ROWS];
  logic [N-1:0] prev_u, prev_p;

  always #10 clk = ~clk;

  card_hole_checker #(.NCOLS(N)) uut (
    .clk(clk), .rst(rst), .cnt_valid(cnt_valid), .cnt_row(cnt_row),
    .ver_valid(ver_valid), .ver_row(ver_row), .card_end(card_end),
    .err_valid(err_valid), .err_flag(err_flag), .err_col(err_col)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_rows();
    for (int r = 0; r < ROWS; r++) begin
      cq[r] = '0;
      vq[r] = '0;
    end
  endtask

  // Feeds 12 row times with card_end on the last row (R11), and a junk
  // cycle with both strobes low after row 5 (R2). Checks the result pulse
  // and that the result holds afterwards (R10).
  task automatic feed_card(input string tag, input int exp_flag, input int exp_col);
    int fl, co;
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      cnt_valid = 1'b1; cnt_row = cq[r];
      ver_valid = 1'b1; ver_row = vq[r];
      card_end  = (r == ROWS - 1);
      if (r == 5) begin
        @(negedge clk);
        cnt_valid = 1'b0; ver_valid = 1'b0; card_end = 1'b0;
        cnt_row = '1; ver_row = '1;
      end
    end
    @(negedge clk);
    cnt_valid = 1'b0; ver_valid = 1'b0; card_end = 1'b0;
    cnt_row = {N{1'b1}}; ver_row = {N{1'b1}};
    check({tag, " R10 pulse"}, int'(err_valid), 1);
    check({tag, " flag"}, int'(err_flag), exp_flag);
    check({tag, " col"}, int'(err_col), exp_col);
    fl = int'(err_flag); co = int'(err_col);
    @(negedge clk);
    check({tag, " R10 single pulse"}, int'(err_valid), 0);
    check({tag, " R10 hold flag"}, int'(err_flag), fl);
    check({tag, " R10 hold col"}, int'(err_col), co);
  endtask

  function automatic logic [N-1:0] gen_row(input int card, input int r);
    logic [N-1:0] v;
    for (int b = 0; b < N; b++) begin
      int h;
      h = card * 131 + r * 17 + b * 29;
      v[b] = ((h * h + b) % 7) == 0;
    end
    return v;
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset valid", int'(err_valid), 0);
    check("R1 reset flag", int'(err_flag), 0);
    check("R1 reset col", int'(err_col), 0);

    // Sweep: each counted card is replayed at the second station one card
    // later, altered in one column by a rotating kind (R3/R4/R5/R7/R8/R9).
    prev_u = '0; prev_p = '0;
    for (int k = 0; k < 30; k++) begin
      logic [N-1:0] vor, vpar, fail, nu, np;
      int col, kind, ec;
      col  = (k * 37 + 3) % N;
      kind = k % 5;
      for (int r = 0; r < ROWS; r++) begin
        cq[r] = gen_row(k, r);
        vq[r] = (k == 0) ? '0 : gen_row(k - 1, r);
      end
      if (k > 0) begin
        case (kind)
          1: vq[k % ROWS][col] = ~vq[k % ROWS][col];
          2: for (int r = 0; r < ROWS; r++) vq[r][col] = 1'b0;
          3: begin vq[0][col] = ~vq[0][col]; vq[1][col] = ~vq[1][col]; end
          4: begin vq[2][col] = 1'b1; vq[9][col] = 1'b1; end
          default: ;
        endcase
      end
      vor = '0; vpar = '0; nu = '0; np = '0;
      for (int r = 0; r < ROWS; r++) begin
        vor |= vq[r]; vpar ^= vq[r];
        nu  |= cq[r]; np   ^= cq[r];
      end
      fail = (prev_u & ~vor) | (prev_p ^ vpar);
      ec = 0;
      for (int b = N - 1; b >= 0; b--) if (fail[b]) ec = b + 1;
      feed_card($sformatf("sweep card %0d kind %0d R3/R4/R7/R8/R9", k, kind),
                (ec != 0) ? 1 : 0, ec);
      prev_u = nu; prev_p = np;
    end

    // Directed sequence from a fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 re-reset flag", int'(err_flag), 0);

    // Card A: count col 5 (row 3) and col 30 (row 0); verify empty bank
    clear_rows();
    cq[3][4] = 1'b1; cq[0][29] = 1'b1;
    feed_card("A R1 empty bank", 0, 0);

    // Card B: col 5 verified 3 times vs 1 (R6), col 10 two extra (R5)
    clear_rows();
    cq[6][79] = 1'b1; cq[2][0] = 1'b1; cq[9][0] = 1'b1;
    vq[1][4] = 1'b1; vq[3][4] = 1'b1; vq[8][4] = 1'b1;
    vq[2][9] = 1'b1; vq[4][9] = 1'b1;
    vq[0][29] = 1'b1;
    feed_card("B R5 R6 same parity", 0, 0);

    // Card C: col 1 missing at station two (R4), col 20 single extra (R5)
    clear_rows();
    vq[5][19] = 1'b1; vq[6][79] = 1'b1;
    feed_card("C R4 R9 lowest", 1, 1);

    // Card D: single extra hole in col 80 on the card_end row (R5 R9 R11)
    clear_rows();
    vq[11][79] = 1'b1;
    feed_card("D R5 R9 R11 last column", 1, 80);

    // Card E: bank that failed in C was cleared (R8)
    clear_rows();
    feed_card("E R8 cleared bank", 0, 0);

    // Card F: count-side row on card_end cycle lands in next verify (R11)
    clear_rows();
    cq[11][39] = 1'b1;
    feed_card("F R11 setup", 0, 0);
    clear_rows();
    feed_card("G R11 counted on end row", 1, 40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule